// File: doc/BRIEF.md
# Static RAM with Flash Clear

A synchronous 1024-word by 4-bit memory with independent data-in and data-out ports. Four active-low controls arrive with the address: chip select, write enable, output enable and clear. The controls are decoded on every rising clock edge into one of four operations: idle, read, write or whole-array clear. Clear beats write, and write beats read.

A clear is accepted only while chip select is low. Many instances can therefore share one clear line, and only the selected ones are wiped. Every word reads as zero once the two-cycle clear window ends. Any read or write presented inside that window is dropped.

The data output is registered. Bus tri-stating is modelled by a separate enable flag. When that flag is low, the data output is held at zero.

Top module: `sram_fclr`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `dout_en` is 0, `dout` is 0, and every address reads back 0.
- R2: A cycle with `cs_n`=0, `clr_n`=1 and `we_n`=0 stores `din` at `addr`, whatever `oe_n` is. `dout_en` is 0 in the following cycle.
- R3: A cycle with `cs_n`=0, `clr_n`=1, `we_n`=1 and `oe_n`=0 is a read. At the next rising edge, `dout` takes the addressed word and `dout_en` goes to 1.
- R4: After any cycle that is not a read, `dout_en` is 0 and `dout` is 0. This covers `cs_n`=1, `oe_n`=1 with no write, a write, and a clear.
- R5: A cycle with `cs_n`=0 and `clr_n`=0 is a clear, whatever `we_n` and `oe_n` are. Any write presented with it is not performed, and every word reads 0 afterwards.
- R6: With `cs_n`=1, `clr_n`=0 has no effect. All stored words are kept.
- R7: The cycle after an accepted clear is a busy cycle. A read or a write presented in it is ignored: no store takes place and `dout_en` stays 0. An operation in the cycle after that behaves normally.
- R8: The array is split into 64 rows of 16 words, with the row given by `addr[9:4]`. After a clear, the first write into a row leaves the other 15 words of that row reading 0, even if they held data before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| clr_n | input | 1 | Array clear request, active low, gated by chip select |
| addr | input | 10 | Word address; bits 9:4 select the row, bits 3:0 the word in the row |
| din | input | 4 | Write data |
| dout | output | 4 | Registered read data, zero when not driven |
| dout_en | output | 1 | High when `dout` would be actively driven |

## Verification
Any stored or flag state that is wrong only becomes visible through a later read, one cycle after that read is presented.

- A row-valid flag that is lost makes a whole row of 16 words read zero.
- A flag that fails to clear lets stale data from before the clear come back.
- A busy flag that is stuck or missing shows up in the very next cycle, either as a dropped operation or as one that should have been dropped.

Full-array sweeps after each phase catch corruption in any row. Reads aimed at the clear window and at the first write into a cleared row cover the timing and the row-zeroing paths.

// File: rtl/sram_fclr_pkg.sv
package sram_fclr_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;
endpackage

// File: rtl/sram_fclr_decode.sv
module sram_fclr_decode
  import sram_fclr_pkg::*;
(
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic clr_n,
  output op_e  op
);
  // Priority: deselect, then clear, then write, then read.
  always_comb begin
    if (cs_n)        op = OP_IDLE;
    else if (!clr_n) op = OP_CLEAR;
    else if (!we_n)  op = OP_WRITE;
    else if (!oe_n)  op = OP_READ;
    else             op = OP_IDLE;
  end
endmodule

// File: rtl/sram_fclr_clear.sv
module sram_fclr_clear #(
  parameter int ROWS  = 64,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_go,
  input  logic             set_en,
  input  logic [ROW_W-1:0] set_row,
  output logic             busy,
  output logic [ROWS-1:0]  row_valid
);
  logic [ROWS-1:0] valid_d, valid_q;
  logic            busy_d, busy_q;

  // Next state: a clear drops every row flag and opens the busy cycle;
  // otherwise a write marks its row as holding real data.
  always_comb begin
    valid_d = valid_q;
    busy_d  = clr_go;
    if (clr_go)      valid_d = '0;
    else if (set_en) valid_d[set_row] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      busy_q  <= busy_d;
    end
  end

  assign busy      = busy_q;
  assign row_valid = valid_q;

  // R5
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_go |=> (busy && row_valid == '0));
  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr_go) |=> !busy);
  // R7
  busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(row_valid));
endmodule

// File: rtl/sram_fclr_array.sv
module sram_fclr_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  parameter int COL_W  = 4,
  localparam int ROW_W    = ADDR_W - COL_W,
  localparam int ROWS     = 1 << ROW_W,
  localparam int ROW_BITS = DATA_W << COL_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              row_ok,
  output logic [DATA_W-1:0] rd_word
);
  logic [ROW_BITS-1:0] mem_q [ROWS];
  logic [ROW_BITS-1:0] row_next;
  logic [ROW_BITS-1:0] row_cur;
  logic [ROW_W-1:0]    row;
  logic [COL_W-1:0]    col;

  assign row     = addr[ADDR_W-1:COL_W];
  assign col     = addr[COL_W-1:0];
  assign row_cur = mem_q[row];

  // A row whose flag is clear holds stale bits; treat it as all zero.
  always_comb begin
    row_next = row_ok ? row_cur : '0;
    row_next[int'(col)*DATA_W +: DATA_W] = din;
  end

  always_comb begin
    rd_word = row_ok ? row_cur[int'(col)*DATA_W +: DATA_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[row] <= row_next;
  end
endmodule

// File: rtl/sram_fclr.sv
module sram_fclr
  import sram_fclr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  parameter int COL_W  = 4,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  op_e              op;
  logic             busy;
  logic [ROWS-1:0]  row_valid;
  logic             clr_go, wr_go, rd_go;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] dout_d, dout_q;
  logic             en_d, en_q;
  logic [ROW_W-1:0] row;

  assign row = addr[ADDR_W-1:COL_W];

  sram_fclr_decode u_dec (
    .cs_n (cs_n),
    .we_n (we_n),
    .oe_n (oe_n),
    .clr_n(clr_n),
    .op   (op)
  );

  assign clr_go = (op == OP_CLEAR);
  assign wr_go  = (op == OP_WRITE) && !busy;
  assign rd_go  = (op == OP_READ)  && !busy;

  sram_fclr_clear #(.ROWS(ROWS), .ROW_W(ROW_W)) u_clr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_go   (clr_go),
    .set_en   (wr_go),
    .set_row  (row),
    .busy     (busy),
    .row_valid(row_valid)
  );

  sram_fclr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_arr (
    .clk    (clk),
    .wr_en  (wr_go),
    .addr   (addr),
    .din    (din),
    .row_ok (row_valid[row]),
    .rd_word(rd_word)
  );

  always_comb begin
    en_d   = rd_go;
    dout_d = rd_go ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      en_q   <= 1'b0;
    end else begin
      dout_q <= dout_d;
      en_q   <= en_d;
    end
  end

  assign dout    = dout_q;
  assign dout_en = en_q;

  // R4
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dout_en);
  // R3
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> dout_en);
  // R4
  zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));
  // R7
  busy_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !dout_en);
endmodule

// File: tb/tb_sram_fclr.sv
module tb_sram_fclr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, we_n, oe_n, clr_n;
  logic [9:0] addr;
  logic [3:0] din;
  logic [3:0] dout;
  logic       dout_en;
  int         checks = 0;
  int         errors = 0;
  logic [3:0] model [1024];

  always #4 clk = ~clk;

  sram_fclr dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .clr_n(clr_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [3:0] pat(input int a);
    return 4'((a * 5 + 3) % 16);
  endfunction

  task automatic check(input string req, input logic en_exp, input logic [3:0] d_exp);
    checks++;
    if (dout_en !== en_exp || dout !== d_exp) begin
      errors++;
      $display("FAIL %s: got en=%b dout=%h expected en=%b dout=%h",
               req, dout_en, dout, en_exp, d_exp);
    end
  endtask

  // Applies inputs at a falling edge; returns at the next falling edge,
  // where the registered result of this cycle is visible.
  task automatic step(input logic cs, input logic we, input logic oe,
                      input logic clr, input int a, input logic [3:0] d);
    cs_n = cs; we_n = we; oe_n = oe; clr_n = clr; addr = 10'(a); din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_chk(input string req, input int a);
    step(1'b0, 1'b1, 1'b0, 1'b1, a, 4'h0);
    check(req, 1'b1, model[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; clr_n = 1'b1;
    addr = '0; din = '0;
    for (int i = 0; i < 1024; i++) model[i] = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset", 1'b0, 4'h0);
    for (int a = 0; a < 1024; a++) read_chk("R1 zero after reset", a);

    // R2: fill with oe_n low too, output must stay off
    for (int a = 0; a < 1024; a++) begin
      step(1'b0, 1'b0, 1'b0, 1'b1, a, pat(a));
      model[a] = pat(a);
      check("R2 write quiet", 1'b0, 4'h0);
    end
    for (int a = 0; a < 1024; a++) read_chk("R3 readback", a);

    // R4: non-read cycles
    step(1'b1, 1'b1, 1'b0, 1'b1, 12, 4'h0);
    check("R4 deselected", 1'b0, 4'h0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 12, 4'h0);
    check("R4 oe high", 1'b0, 4'h0);

    // R6: clear with chip deselected, write also presented
    step(1'b1, 1'b0, 1'b0, 1'b0, 9, 4'hF);
    check("R6 gated clear quiet", 1'b0, 4'h0);
    for (int a = 0; a < 1024; a++) read_chk("R6 kept", a);

    // R5: clear with write and oe low; write data must not land
    step(1'b0, 1'b0, 1'b0, 1'b0, 5, 4'h9);
    for (int i = 0; i < 1024; i++) model[i] = 4'h0;
    check("R4 clear quiet", 1'b0, 4'h0);
    // R7: busy-cycle write ignored
    step(1'b0, 1'b0, 1'b1, 1'b1, 6, 4'hA);
    check("R7 busy quiet", 1'b0, 4'h0);
    // R7: third cycle write takes effect
    step(1'b0, 1'b0, 1'b1, 1'b1, 7, 4'hC);
    model[7] = 4'hC;
    read_chk("R5 clear beats write", 5);
    read_chk("R7 busy write dropped", 6);
    // R8: rest of row 0 reads zero despite stale data
    for (int a = 0; a < 16; a++) read_chk("R8 row zeroed", a);
    for (int a = 16; a < 1024; a++) read_chk("R5 cleared", a);

    // R7: read in busy cycle ignored, next read works
    step(1'b0, 1'b1, 1'b1, 1'b0, 7, 4'h0);
    model[7] = 4'h0;
    step(1'b0, 1'b1, 1'b0, 1'b1, 7, 4'h0);
    check("R7 busy read", 1'b0, 4'h0);
    read_chk("R7 after window", 7);

    // R8: two writes in one row after clear
    step(1'b0, 1'b0, 1'b1, 1'b1, 10'h35, 4'h6);
    model[10'h35] = 4'h6;
    step(1'b0, 1'b0, 1'b1, 1'b1, 10'h3A, 4'h9);
    model[10'h3A] = 4'h9;
    for (int a = 10'h30; a < 10'h40; a++) read_chk("R8 row words", a);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule